// File: doc/BRIEF.md
# Sleep-Mode Wake Source Controller

This block watches external pins and a few internal events while the chip is held in a sleep mode. When an enabled source produces a qualified event, the block raises a wake request to the power sequencer, which then releases the processor from reset. For every source it also keeps a sticky flag, so firmware can read after start-up which source ended the sleep. Reset-type sources are always enabled. They set flags in a separate register and never raise the wake request.

Every asynchronous pin passes through a two-flop synchronizer on the slow clock. A per-source qualifier then applies the source's trigger type (high level, rising edge or either edge) and its hold time. The qualified condition must stay stable for that many consecutive cycles before it counts, and a shorter glitch is dropped. Hold times are derived from the clock frequency parameter: a long hold of 64 ms for debounced sources and a short hold of about 2 µs for the others, never less than one cycle. One flag position is shared by two pins. A select bit chooses between the level-sensitive general input 55 with the long hold and either edge of the optical receive line with the short hold. Firmware reaches enables, configuration and flags through a small register bus. Writes are synchronous, reads are combinational and flags are cleared by writing one.

Top module: `wake_ctl`

## Requirements
- R1: After reset, both flag registers read 0 and `wake_req_o` is 0. The enable and configuration registers also read 0.
- R2: Pushbutton (wake flag bit 3, address 0) triggers on high level with the long hold. If its enable (address 2 bit 3) is set, the flag is set on every qualified press whether or not `sleep_i` is high. With the pin driven high before clock edge 1, the flag first reads 1 after edge LONG_CYC+2 and not after edge LONG_CYC+1.
- R3: Every wake flag other than the pushbutton is set only when its event qualifies while `sleep_i` is high. The same event while awake leaves address 0 unchanged.
- R4: The serial receive pin (wake flag bit 4, enable bit 4) triggers on either edge with the short hold. It idles high.
- R5: General input 4 (wake flag bit 2, enable bit 2) triggers on a rising edge with the short hold. The flag first reads 1 after edge SHORT_CYC+2 counted from the pin change.
- R6: General input 52 (wake flag bit 1, enable bit 1) triggers on high level with the long hold. A high pulse shorter than the hold sets nothing.
- R7: Wake flag bit 0 (enable bit 0) comes from one of two pins, chosen by configuration bit 1 (address 3). With the bit set, general input 55 counts as a high level with the long hold. With it clear, either edge of the optical receive line counts with the short hold. The pin that is not selected has no effect.
- R8: A general input takes part only when its enable bit is set and its input-mode bit in address 3 is set. The input-mode bits are bit 2 for input 4, bit 3 for input 52 and bit 4 for input 55.
- R9: A one-cycle `tmr_expire_i` pulse while asleep sets wake flag bit 5 at the next edge, but only when the arm bit (address 3 bit 0) is set.
- R10: Reset sources always set their flags in address 1. These are the reset pin (bit 6, high level, short hold), the software reset pulse (bit 5, next edge) and the emulator reset pin (bit 4 is not used; bit 3, high level, short hold). This holds regardless of enables and sleep state.
- R11: `wake_req_o` rises at the same edge as the flag of an enabled event that qualifies while asleep. It stays high while `sleep_i` is high and is 0 after the first edge at which `sleep_i` is low.
- R12: Writing to address 0 or 1 clears exactly the flag bits written as one. When a clear and a new event for the same bit happen in the same cycle, the flag stays set.
- R13: A set flag stays set through any later transitions of its source until firmware clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_i | input | 1 | High while the chip is in a sleep mode |
| pb_pin_i | input | 1 | Pushbutton pin, asynchronous |
| rx_pin_i | input | 1 | Serial receive pin, asynchronous, idles high |
| in4_pin_i | input | 1 | General input 4, asynchronous |
| in52_pin_i | input | 1 | General input 52, asynchronous |
| in55_pin_i | input | 1 | General input 55, asynchronous |
| opt_pin_i | input | 1 | Optical receive pin, asynchronous, idles high |
| rst_pin_i | input | 1 | External reset pin, asynchronous |
| emu_rst_i | input | 1 | Emulator reset request, asynchronous |
| tmr_expire_i | input | 1 | Wake timer expiry pulse, synchronous |
| sw_rst_i | input | 1 | Software reset pulse, synchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 2 | Write address |
| reg_wdata_i | input | 8 | Write data |
| reg_raddr_i | input | 2 | Read address |
| reg_rdata_o | output | 8 | Read data, combinational |
| wake_req_o | output | 1 | Wake request to the power sequencer |

## Verification
The assertions assume that `sleep_i`, `tmr_expire_i`, `sw_rst_i` and the register bus are synchronous to `clk`, and that flags fall only after a write to their own address. The bench changes every input one time unit after a rising edge, so synchronous inputs never move near an edge. It holds pins steady for whole cycle counts and leaves `sleep_i` fixed across each qualification window. It also counts every latency from the pin change through both synchronizer stages and the hold counter.

// File: rtl/wake_pkg.sv
package wake_pkg;
    // Trigger type applied by a qualifier
    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_RISE  = 2'd1,
        TRIG_BOTH  = 2'd2
    } trig_e;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;
    localparam int WF_W   = 6;
    localparam int EN_W   = 5;
    localparam int CFG_W  = 5;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_WFLAG = 2'd0;
    localparam logic [ADDR_W-1:0] A_RFLAG = 2'd1;
    localparam logic [ADDR_W-1:0] A_WEN   = 2'd2;
    localparam logic [ADDR_W-1:0] A_CFG   = 2'd3;

    // Wake flag and enable bit positions
    localparam int B_TMR  = 5;
    localparam int B_RX   = 4;
    localparam int B_PB   = 3;
    localparam int B_IN4  = 2;
    localparam int B_IN52 = 1;
    localparam int B_SRC0 = 0;

    // Reset flag bit positions
    localparam int R_PIN = 6;
    localparam int R_SW  = 5;
    localparam int R_EMU = 3;
    localparam logic [REG_W-1:0] RFLAG_MASK = 8'b0110_1000;

    // Configuration bit positions
    localparam int C_ARM  = 0;
    localparam int C_SEL  = 1;
    localparam int C_IN4  = 2;
    localparam int C_IN52 = 3;
    localparam int C_IN55 = 4;

    // Synchronized source indices
    localparam int NSRC   = 8;
    localparam int S_PB   = 0;
    localparam int S_RX   = 1;
    localparam int S_IN4  = 2;
    localparam int S_IN52 = 3;
    localparam int S_IN55 = 4;
    localparam int S_OPT  = 5;
    localparam int S_RPIN = 6;
    localparam int S_EMU  = 7;
endpackage

// File: rtl/wake_sync.sv
// wake_sync: two-flop synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent; the reset value per bit is the idle level.
module wake_sync #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Two capture stages toward the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/wake_qual.sv
// wake_qual: turns one synchronized pin into a single-cycle qualified event.
// Level and rising types fire once per high period; the either-edge type
// fires once per change of level. The condition must hold HOLD consecutive
// cycles; any break restarts the count. Assumes HOLD >= 1.
module wake_qual
    import wake_pkg::*;
#(
    parameter trig_e       TRIG = TRIG_LEVEL,
    parameter int unsigned HOLD = 1,
    parameter logic        IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    output logic fire_o
);
    localparam int   CW      = (HOLD < 2) ? 1 : $clog2(HOLD);
    localparam logic REF_RST = (TRIG == TRIG_LEVEL) ? 1'b0 :
                               (TRIG == TRIG_RISE)  ? 1'b1 : IDLE;
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic          ref_q;
    logic [CW-1:0] cnt_q;
    logic          cond;

    // Pending condition: level differs from reference (either edge) or high while unarmed
    always_comb begin
        if (TRIG == TRIG_BOTH) cond = (pin_s != ref_q);
        else                   cond = pin_s & ~ref_q;
        fire_o = cond && (cnt_q == LAST);
    end

    // Hold counter and reference level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= REF_RST;
            cnt_q <= '0;
        end else if (fire_o) begin
            cnt_q <= '0;
            ref_q <= (TRIG == TRIG_BOTH) ? pin_s : 1'b1;
        end else if (cond) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
            if (TRIG != TRIG_BOTH && !pin_s) ref_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wake_regs.sv
// wake_regs: enable, configuration and flag registers plus wake request.
// Gates qualified events by enable, input mode and sleep state, selects
// the shared flag-0 source, and applies write-one-to-clear with set priority.
// Assumes bus signals are synchronous to clk.
module wake_regs
    import wake_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic [NSRC-1:0]   fire_i,
    input  logic              tmr_expire_i,
    input  logic              sw_rst_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_waddr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    input  logic [ADDR_W-1:0] reg_raddr_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic [WF_W-1:0]   wflag_o,
    output logic [REG_W-1:0]  rflag_o,
    output logic              wake_req_o
);
    localparam logic [WF_W-1:0] AWAKE_MASK = WF_W'(1) << B_PB;

    logic [EN_W-1:0]  en_q;
    logic [CFG_W-1:0] cfg_q;
    logic [WF_W-1:0]  wflag_q;
    logic [REG_W-1:0] rflag_q;
    logic             wake_q;
    logic [WF_W-1:0]  ev;
    logic [WF_W-1:0]  wset;
    logic [WF_W-1:0]  wclr;
    logic [REG_W-1:0] rset;
    logic [REG_W-1:0] rclr;

    // Enabled wake events per flag position
    always_comb begin
        ev          = '0;
        ev[B_TMR]   = tmr_expire_i & cfg_q[C_ARM];
        ev[B_RX]    = fire_i[S_RX] & en_q[B_RX];
        ev[B_PB]    = fire_i[S_PB] & en_q[B_PB];
        ev[B_IN4]   = fire_i[S_IN4] & en_q[B_IN4] & cfg_q[C_IN4];
        ev[B_IN52]  = fire_i[S_IN52] & en_q[B_IN52] & cfg_q[C_IN52];
        ev[B_SRC0]  = en_q[B_SRC0] &
                      (cfg_q[C_SEL] ? (fire_i[S_IN55] & cfg_q[C_IN55]) : fire_i[S_OPT]);
        wset        = sleep_i ? ev : (ev & AWAKE_MASK);
        wclr        = (reg_we_i && reg_waddr_i == A_WFLAG) ? reg_wdata_i[WF_W-1:0] : '0;
        rset        = '0;
        rset[R_PIN] = fire_i[S_RPIN];
        rset[R_SW]  = sw_rst_i;
        rset[R_EMU] = fire_i[S_EMU];
        rclr        = (reg_we_i && reg_waddr_i == A_RFLAG) ? (reg_wdata_i & RFLAG_MASK) : '0;
    end

    // Register state: control writes, sticky flags, wake request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            cfg_q   <= '0;
            wflag_q <= '0;
            rflag_q <= '0;
            wake_q  <= 1'b0;
        end else begin
            if (reg_we_i && reg_waddr_i == A_WEN) en_q  <= reg_wdata_i[EN_W-1:0];
            if (reg_we_i && reg_waddr_i == A_CFG) cfg_q <= reg_wdata_i[CFG_W-1:0];
            wflag_q <= (wflag_q & ~wclr) | wset;
            rflag_q <= (rflag_q & ~rclr) | rset;
            wake_q  <= sleep_i ? (wake_q | (|ev)) : 1'b0;
        end
    end

    // Combinational read mux
    always_comb begin
        case (reg_raddr_i)
            A_WFLAG: reg_rdata_o = REG_W'(wflag_q);
            A_RFLAG: reg_rdata_o = rflag_q;
            A_WEN:   reg_rdata_o = REG_W'(en_q);
            default: reg_rdata_o = REG_W'(cfg_q);
        endcase
    end

    assign wflag_o    = wflag_q;
    assign rflag_o    = rflag_q;
    assign wake_req_o = wake_q;
endmodule

// File: rtl/wake_ctl.sv
// wake_ctl: top of the sleep-mode wake source controller.
// Synchronizes all pins, qualifies each with its own trigger type and
// hold time, and hands qualified events to the register block.
// Assumes clk is the always-on slow clock and CLK_HZ matches it.
module wake_ctl
    import wake_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 32768,
    parameter int unsigned LONG_MS  = 64,
    parameter int unsigned SHORT_US = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              pb_pin_i,
    input  logic              rx_pin_i,
    input  logic              in4_pin_i,
    input  logic              in52_pin_i,
    input  logic              in55_pin_i,
    input  logic              opt_pin_i,
    input  logic              rst_pin_i,
    input  logic              emu_rst_i,
    input  logic              tmr_expire_i,
    input  logic              sw_rst_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_waddr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    input  logic [ADDR_W-1:0] reg_raddr_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              wake_req_o
);
    localparam longint unsigned LONG_RAW  = (64'(CLK_HZ) * 64'(LONG_MS) + 64'd999) / 64'd1000;
    localparam longint unsigned SHORT_RAW = (64'(CLK_HZ) * 64'(SHORT_US) + 64'd999999) / 64'd1000000;
    localparam int unsigned LONG_CYC  = (LONG_RAW == 0)  ? 1 : int'(LONG_RAW);
    localparam int unsigned SHORT_CYC = (SHORT_RAW == 0) ? 1 : int'(SHORT_RAW);

    // Per-source trigger type, hold choice and idle level (index = S_*)
    localparam logic [2*NSRC-1:0] TRIG_TAB = {
        2'(TRIG_LEVEL), 2'(TRIG_LEVEL), 2'(TRIG_BOTH), 2'(TRIG_LEVEL),
        2'(TRIG_LEVEL), 2'(TRIG_RISE),  2'(TRIG_BOTH), 2'(TRIG_LEVEL)
    };
    localparam logic [NSRC-1:0] LONG_SEL = 8'b0001_1001;
    localparam logic [NSRC-1:0] IDLE_TAB = 8'b0010_0010;

    logic [NSRC-1:0] pin_v;
    logic [NSRC-1:0] sync_v;
    logic [NSRC-1:0] fire_v;
    logic [WF_W-1:0] wflag;
    logic [REG_W-1:0] rflag;

    // Gather pins in source-index order
    always_comb begin
        pin_v         = '0;
        pin_v[S_PB]   = pb_pin_i;
        pin_v[S_RX]   = rx_pin_i;
        pin_v[S_IN4]  = in4_pin_i;
        pin_v[S_IN52] = in52_pin_i;
        pin_v[S_IN55] = in55_pin_i;
        pin_v[S_OPT]  = opt_pin_i;
        pin_v[S_RPIN] = rst_pin_i;
        pin_v[S_EMU]  = emu_rst_i;
    end

    wake_sync #(.W(NSRC), .RST_VAL(IDLE_TAB)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_v),
        .sync_o  (sync_v)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_qual
        wake_qual #(
            .TRIG (trig_e'(TRIG_TAB[2*g +: 2])),
            .HOLD (LONG_SEL[g] ? LONG_CYC : SHORT_CYC),
            .IDLE (IDLE_TAB[g])
        ) u_q (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_s  (sync_v[g]),
            .fire_o (fire_v[g])
        );
    end

    wake_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_i      (sleep_i),
        .fire_i       (fire_v),
        .tmr_expire_i (tmr_expire_i),
        .sw_rst_i     (sw_rst_i),
        .reg_we_i     (reg_we_i),
        .reg_waddr_i  (reg_waddr_i),
        .reg_wdata_i  (reg_wdata_i),
        .reg_raddr_i  (reg_raddr_i),
        .reg_rdata_o  (reg_rdata_o),
        .wflag_o      (wflag),
        .rflag_o      (rflag),
        .wake_req_o   (wake_req_o)
    );
endmodule

// File: rtl/wake_ctl_chk.sv
// wake_ctl_chk: temporal checks on the wake controller, bound to wake_ctl.
// Assumes sleep_i and the register bus are synchronous to clk.
module wake_ctl_chk
    import wake_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_i,
    input logic              reg_we_i,
    input logic [ADDR_W-1:0] reg_waddr_i,
    input logic [WF_W-1:0]   wflag,
    input logic [REG_W-1:0]  rflag,
    input logic              wake_req_o
);
    localparam logic [WF_W-1:0] SLEEP_ONLY = 6'b110111;

    // Leaving reset starts with clear flags and no request
    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (wflag == '0 && rflag == '0 && !wake_req_o));

    // Non-pushbutton wake flags never rise while awake
    assert_awake_no_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sleep_i) |-> ((wflag & ~$past(wflag) & SLEEP_ONLY) == '0));

    // A new non-pushbutton flag while asleep comes with the wake request
    assert_flag_brings_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sleep_i) && ((wflag & ~$past(wflag) & SLEEP_ONLY) != '0)) |-> wake_req_o);

    // Request drops once the sequencer leaves sleep
    assert_wake_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_i |=> !wake_req_o);

    // Wake flags fall only through a write to their address
    assert_wflag_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we_i && reg_waddr_i == A_WFLAG) |=> ((wflag & $past(wflag)) == $past(wflag)));

    // Reset flags fall only through a write to their address
    assert_rflag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we_i && reg_waddr_i == A_RFLAG) |=> ((rflag & $past(rflag)) == $past(rflag)));
endmodule

bind wake_ctl wake_ctl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_i     (sleep_i),
    .reg_we_i    (reg_we_i),
    .reg_waddr_i (reg_waddr_i),
    .wflag       (wflag),
    .rflag       (rflag),
    .wake_req_o  (wake_req_o)
);

// File: tb/wake_ctl_tb_top.sv
module wake_ctl_tb_top;
    // Hold times from the requirements at the default 32768 Hz clock
    localparam int LONG  = 2098;
    localparam int SHORT = 1;
    localparam int LAT_L = LONG + 2;
    localparam int LAT_S = SHORT + 2;

    typedef struct {
        logic [1:0] addr;
        logic [7:0] data;
        logic       wake;
        string      tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep = 1'b0;
    logic pb = 0, rx = 1, in4 = 0, in52 = 0, in55 = 0, opt = 1, rpin = 0, emu = 0;
    logic tmr = 0, swr = 0;
    logic we = 0;
    logic [1:0] waddr = '0, raddr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic wake;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    item_t sb_q[$];

    always #5 clk = ~clk;

    wake_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep),
        .pb_pin_i(pb), .rx_pin_i(rx), .in4_pin_i(in4), .in52_pin_i(in52),
        .in55_pin_i(in55), .opt_pin_i(opt), .rst_pin_i(rpin), .emu_rst_i(emu),
        .tmr_expire_i(tmr), .sw_rst_i(swr),
        .reg_we_i(we), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
        .reg_raddr_i(raddr), .reg_rdata_o(rdata), .wake_req_o(wake)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        we = 1; waddr = a; wdata = d;
        step(1);
        we = 0;
    endtask

    // Driver: set read address, push the expected item, wait for the monitor
    task automatic expect_reg(input logic [1:0] a, input logic [7:0] d,
                              input logic w, input string tag);
        item_t it;
        raddr = a;
        #1;
        it.addr = a; it.data = d; it.wake = w; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    // Monitor: pop and compare against the design outputs
    initial begin
        forever begin
            item_t it;
            wait (sb_q.size() > 0);
            it = sb_q[0];
            n_cmp++;
            if (rdata !== it.data || wake !== it.wake) begin
                n_bad++;
                $display("FAIL %s: addr %0d rdata=%h wake=%b, expected rdata=%h wake=%b",
                         it.tag, it.addr, rdata, wake, it.data, it.wake);
            end
            void'(sb_q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        expect_reg(0, 8'h00, 0, "R1 wake flags");
        expect_reg(1, 8'h00, 0, "R1 reset flags");
        expect_reg(2, 8'h00, 0, "R1 enables");
        wr(2, 8'h1F);
        wr(3, 8'h1D);

        // Awake: general input ignored, pushbutton still flags (R3, R2)
        in4 = 1; step(LAT_S + 2);
        expect_reg(0, 8'h00, 0, "R3 in4 while awake");
        in4 = 0; step(3);
        pb = 1; step(LAT_L - 1);
        expect_reg(0, 8'h00, 0, "R2 pb before hold ends");
        step(1);
        expect_reg(0, 8'h08, 0, "R2 pb awake");
        pb = 0;
        wr(0, 8'h08);
        expect_reg(0, 8'h00, 0, "R12 clear pb");

        // Asleep: input 4 rising edge (R5, R11, R13)
        sleep = 1; step(1);
        in4 = 1; step(LAT_S - 1);
        expect_reg(0, 8'h00, 0, "R5 before latency");
        step(1);
        expect_reg(0, 8'h04, 1, "R5 R11 in4 wake");
        in4 = 0; step(3); in4 = 1; step(5);
        expect_reg(0, 8'h04, 1, "R13 sticky");
        sleep = 0; step(1);
        expect_reg(0, 8'h04, 0, "R11 release");
        in4 = 0;
        wr(0, 8'h3F);

        // Serial receive, both edges (R4)
        sleep = 1; step(1);
        rx = 0; step(LAT_S);
        expect_reg(0, 8'h10, 1, "R4 falling edge");
        sleep = 0; step(1);
        wr(0, 8'h10);
        sleep = 1; step(1);
        rx = 1; step(LAT_S);
        expect_reg(0, 8'h10, 1, "R4 rising edge");
        sleep = 0; step(1);
        wr(0, 8'h3F);

        // Input 52 long hold (R6)
        sleep = 1; step(1);
        in52 = 1; step(100); in52 = 0; step(LONG);
        expect_reg(0, 8'h00, 0, "R6 short pulse");
        in52 = 1; step(LAT_L - 1);
        expect_reg(0, 8'h00, 0, "R6 before hold ends");
        step(1);
        expect_reg(0, 8'h02, 1, "R6 level held");
        in52 = 0;
        sleep = 0; step(1);
        wr(0, 8'h3F);

        // Shared flag 0 selection (R7)
        sleep = 1; step(1);
        in55 = 1; step(LAT_L + 5);
        expect_reg(0, 8'h00, 0, "R7 in55 unselected");
        opt = 0; step(LAT_S);
        expect_reg(0, 8'h01, 1, "R7 optical edge");
        in55 = 0; opt = 1; step(5);
        sleep = 0; step(1);
        wr(0, 8'h3F);
        wr(3, 8'h1F);
        sleep = 1; step(1);
        opt = 0; step(5);
        expect_reg(0, 8'h00, 0, "R7 optical unselected");
        in55 = 1; step(LAT_L);
        expect_reg(0, 8'h01, 1, "R7 in55 level");
        in55 = 0; opt = 1; step(5);
        sleep = 0; step(1);
        wr(0, 8'h3F);

        // Enable and input-mode gating (R8)
        wr(2, 8'h1B);
        sleep = 1; step(1);
        in4 = 1; step(LAT_S + 2);
        expect_reg(0, 8'h00, 0, "R8 enable off");
        in4 = 0;
        wr(2, 8'h1F);
        wr(3, 8'h17);
        in52 = 1; step(LAT_L + 2);
        expect_reg(0, 8'h00, 0, "R8 input mode off");
        in52 = 0;
        wr(3, 8'h1F);
        step(3);

        // Timer and clear-versus-set (R9, R12)
        tmr = 1; step(1); tmr = 0;
        expect_reg(0, 8'h20, 1, "R9 timer armed");
        we = 1; waddr = 0; wdata = 8'h20; tmr = 1;
        step(1);
        we = 0; tmr = 0;
        expect_reg(0, 8'h20, 1, "R12 event wins");
        wr(0, 8'h20);
        expect_reg(0, 8'h00, 1, "R12 clear timer");
        wr(3, 8'h1E);
        tmr = 1; step(1); tmr = 0;
        expect_reg(0, 8'h00, 1, "R9 timer disarmed");
        sleep = 0; step(1);

        // Reset sources, always enabled (R10)
        wr(2, 8'h00);
        rpin = 1; step(LAT_S);
        expect_reg(1, 8'h40, 0, "R10 reset pin");
        rpin = 0;
        swr = 1; step(1); swr = 0;
        expect_reg(1, 8'h60, 0, "R10 software reset");
        emu = 1; step(LAT_S);
        expect_reg(1, 8'h68, 0, "R10 emulator reset");
        emu = 0;
        wr(1, 8'h20);
        expect_reg(1, 8'h48, 0, "R12 partial clear");
        expect_reg(0, 8'h00, 0, "R10 no wake flag");

        // Pushbutton while asleep (R2)
        wr(2, 8'h1F);
        sleep = 1; step(1);
        pb = 1; step(LAT_L);
        expect_reg(0, 8'h08, 1, "R2 pb asleep");
        pb = 0;
        step(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule